// File: doc/BRIEF.md
# Trimmed One-Second Prescaler with Frequency-Test Output

This block divides a nominal 32,768 Hz oscillator, presented as a single-cycle enable `osc_ce` in the system clock domain, down to one pulse per second. A digital trim corrects the oscillator's frequency error without touching the crystal. The trim is a magnitude and a direction. Over a repeating cycle of 64 minutes, a few selected seconds are made shorter or longer by a fixed number of oscillator counts. The amount of each correction is set by the position of the trim tap in the divider chain. At the default sizes that tap is the divide-by-256 point.

The block also provides a 512 Hz square wave taken from a free-running stage ahead of the trim. Test equipment can measure the raw oscillator rate from this wave while a trim is in effect. The wave is gated so that it appears only when the frequency-test flag is set, the oscillator is running, and the seconds location is being read. A halt flag freezes all divider state, so no oscillator counts are lost or gained across a pause.

Top module: `cal_prescale`

## Requirements
- R1: With no trim in effect, `sec_tick` pulses high for exactly one clock after every 2^SEC_W counted oscillator enables (32,768 by default). It goes high in the clock that follows the enable that completes the second.
- R2: The adjustment cycle is 2^(MAG_W+1) minutes (64 by default), each of SPM seconds. The only second that can be adjusted is the first second of a minute, and it is adjusted only when that minute's index, counted from 0 at the start of the cycle, is below twice the active trim magnitude.
- R3: With `trim_up`=1 (speed up), each adjusted second lasts 2^SEC_W − 2^LO_W enables (32,512 by default).
- R4: With `trim_up`=0 (slow down), each adjusted second lasts 2^SEC_W + 2^(LO_W−1) enables (32,896 by default). A magnitude of 0 adjusts nothing, whatever the direction.
- R5: The block samples `trim_mag` and `trim_up` only on the enable that ends the last second of the last minute of a cycle. The sampled value governs the whole of the next cycle. The cycle that starts at reset runs with a zero trim, whatever the inputs are.
- R6: While `halt`=1, oscillator enables are not counted, no `sec_tick` is produced, and the 512 Hz stage holds its state. After `halt` falls, counting continues from the held count, so the interrupted second still totals its full count of enables.
- R7: `ftest_drive` is 1 exactly when `ftest_en`=1, `halt`=0 and `sec_read`=1. `ftest_out` is 0 whenever `ftest_drive` is 0. While it is driven, `ftest_out` is a square wave with a period of 2^TEST_W enables (64 by default, giving 512 Hz).
- R8: The `ftest_out` period is not altered by any trim value, including seconds that are being shortened or lengthened.
- R9: While `rst_n`=0, `sec_tick` and `ftest_out` are 0, and all counters, the cycle position and the active trim return to zero.
- R10: Only clocks with `osc_ce`=1 advance the divider. Gaps in the enable stretch the second in clocks but not in counted enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_ce | input | 1 | One-clock enable per oscillator period |
| trim_mag | input | MAG_W | Trim magnitude, 0 to 2^MAG_W−1 |
| trim_up | input | 1 | Trim direction: 1 shortens adjusted seconds, 0 lengthens them |
| halt | input | 1 | Freezes the divider |
| ftest_en | input | 1 | Frequency-test request |
| sec_read | input | 1 | Qualifier: the seconds location is being read |
| sec_tick | output | 1 | One-clock pulse per completed second |
| ftest_out | output | 1 | Gated 512 Hz test square wave |
| ftest_drive | output | 1 | High when `ftest_out` carries the test wave |

## Verification
The bench tracks the cycle position of every tick and checks every second across several full adjustment cycles. A design that adjusts the wrong second of a minute, or too many minutes, shows up as single periods of the wrong length. An off-by-one in the trim amounts shows up as periods of 111, 113, 135 or 137 instead of 112 or 136. Trim values are changed partway through a cycle, so a design that applies a new trim at once, rather than at the cycle boundary, distorts the seconds that remain in that cycle. A design that keeps counting during a halt, or counts clocks instead of enables, gives a short period in the halted or gapped second. A test wave derived after the trim tap changes period inside adjusted seconds.

// File: rtl/cal_prescale_pkg.sv
`timescale 1ns/1ps
package cal_prescale_pkg;

   // Kind of correction applied to the second currently being counted.
   typedef enum logic [1:0] {
      ADJ_NONE = 2'd0,
      ADJ_FAST = 2'd1,
      ADJ_SLOW = 2'd2
   } adj_e;

endpackage

// File: rtl/ftest_div.sv
`timescale 1ns/1ps
// Free-running stage ahead of the trim tap; its MSB is the test square wave.
module ftest_div #(
   parameter int TEST_W = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic wave
);
   logic [TEST_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (step)  cnt_q <= cnt_q + 1'b1;
   end

   assign wave = cnt_q[TEST_W-1];
endmodule

// File: rtl/sec_sched.sv
`timescale 1ns/1ps
// Tracks second-in-minute and minute-in-cycle, holds the active trim and
// decides whether the current second is corrected.
module sec_sched
   import cal_prescale_pkg::*;
#(
   parameter int MAG_W = 5,
   parameter int SPM   = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_end,
   input  logic [MAG_W-1:0] trim_mag,
   input  logic             trim_up,
   output adj_e             adj,
   output logic [MAG_W-1:0] act_mag,
   output logic [$clog2(SPM)-1:0] sec_idx,
   output logic [MAG_W:0]   min_idx
);
   localparam int SPM_W = $clog2(SPM);
   localparam int MIN_W = MAG_W + 1;
   localparam logic [SPM_W-1:0] SEC_LAST = SPM_W'(SPM - 1);
   localparam logic [MIN_W-1:0] MIN_LAST = {MIN_W{1'b1}};

   logic act_up_q;
   logic min_wrap;
   logic cyc_wrap;

   assign min_wrap = sec_end && (sec_idx == SEC_LAST);
   assign cyc_wrap = min_wrap && (min_idx == MIN_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_idx  <= '0;
         min_idx  <= '0;
         act_mag  <= '0;
         act_up_q <= 1'b0;
      end else begin
         if (sec_end)  sec_idx <= min_wrap ? '0 : sec_idx + 1'b1;
         if (min_wrap) min_idx <= min_idx + 1'b1;
         if (cyc_wrap) begin
            act_mag  <= trim_mag;
            act_up_q <= trim_up;
         end
      end
   end

   always_comb begin
      adj = ADJ_NONE;
      if ((sec_idx == '0) && (min_idx < {act_mag, 1'b0}))
         adj = act_up_q ? ADJ_FAST : ADJ_SLOW;
   end
endmodule

// File: rtl/sec_count.sv
`timescale 1ns/1ps
// Counts oscillator steps in one second; the terminal count follows the
// correction requested for that second.
module sec_count
   import cal_prescale_pkg::*;
#(
   parameter int SEC_W = 15,
   parameter int LO_W  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  adj_e adj,
   output logic sec_end,
   output logic tick
);
   localparam int CNT_W  = SEC_W + 1;
   localparam int NOM_I  = (2 ** SEC_W) - 1;
   localparam int FAST_I = NOM_I - (2 ** LO_W);
   localparam int SLOW_I = NOM_I + (2 ** (LO_W - 1));
   localparam logic [CNT_W-1:0] T_NOM  = CNT_W'(NOM_I);
   localparam logic [CNT_W-1:0] T_FAST = CNT_W'(FAST_I);
   localparam logic [CNT_W-1:0] T_SLOW = CNT_W'(SLOW_I);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;

   always_comb begin
      unique case (adj)
         ADJ_FAST: term = T_FAST;
         ADJ_SLOW: term = T_SLOW;
         default:  term = T_NOM;
      endcase
   end

   assign sec_end = step && (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else begin
         tick <= sec_end;
         if (sec_end)   cnt_q <= '0;
         else if (step) cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cal_prescale.sv
`timescale 1ns/1ps
module cal_prescale
   import cal_prescale_pkg::*;
#(
   parameter int SEC_W  = 15,
   parameter int LO_W   = 8,
   parameter int TEST_W = 6,
   parameter int MAG_W  = 5,
   parameter int SPM    = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_ce,
   input  logic [MAG_W-1:0] trim_mag,
   input  logic             trim_up,
   input  logic             halt,
   input  logic             ftest_en,
   input  logic             sec_read,
   output logic             sec_tick,
   output logic             ftest_out,
   output logic             ftest_drive
);
   localparam int SPM_W = $clog2(SPM);

   generate
      if (LO_W < 1 || LO_W >= SEC_W) begin : g_bad_lo
         $error("cal_prescale: LO_W must lie in 1..SEC_W-1");
      end
      if (TEST_W < 1 || TEST_W > SEC_W) begin : g_bad_test
         $error("cal_prescale: TEST_W must lie in 1..SEC_W");
      end
      if (SPM < 2) begin : g_bad_spm
         $error("cal_prescale: SPM must be at least 2");
      end
      if (MAG_W < 1) begin : g_bad_mag
         $error("cal_prescale: MAG_W must be at least 1");
      end
   endgenerate

   logic             step;
   logic             sec_end;
   logic             wave_raw;
   adj_e             adj;
   logic [MAG_W-1:0] act_mag;
   logic [SPM_W-1:0] sec_idx;
   logic [MAG_W:0]   min_idx;

   assign step = osc_ce && !halt;

   ftest_div #(.TEST_W(TEST_W)) u_ftest (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .wave  (wave_raw)
   );

   sec_sched #(.MAG_W(MAG_W), .SPM(SPM)) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_end  (sec_end),
      .trim_mag (trim_mag),
      .trim_up  (trim_up),
      .adj      (adj),
      .act_mag  (act_mag),
      .sec_idx  (sec_idx),
      .min_idx  (min_idx)
   );

   sec_count #(.SEC_W(SEC_W), .LO_W(LO_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .adj     (adj),
      .sec_end (sec_end),
      .tick    (sec_tick)
   );

   assign ftest_drive = ftest_en && !halt && sec_read;
   assign ftest_out   = ftest_drive && wave_raw;
endmodule

// File: rtl/cal_prescale_chk.sv
`timescale 1ns/1ps
module cal_prescale_chk
   import cal_prescale_pkg::*;
#(
   parameter int MAG_W = 5,
   parameter int SPM_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             osc_ce,
   input logic             halt,
   input logic             sec_tick,
   input logic             wave_raw,
   input adj_e             adj,
   input logic [MAG_W-1:0] act_mag,
   input logic [SPM_W-1:0] sec_idx,
   input logic [MAG_W:0]   min_idx
);
   // R1: a tick lasts one clock
   assert_tick_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   // R6: no tick can follow a halted clock
   assert_halt_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !sec_tick);

   // R6: the test stage is frozen while halted
   assert_halt_wave_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> $stable(wave_raw));

   // R10: a tick needs a counted enable on the previous clock
   assert_tick_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> $past(osc_ce && !halt));

   // R5: the active trim only changes as a new cycle begins
   assert_trim_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_mag) |-> (min_idx == '0 && sec_idx == '0));

   // R4: a zero magnitude never produces a correction
   assert_adj_needs_mag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (adj != ADJ_NONE) |-> (act_mag != '0));
endmodule

bind cal_prescale cal_prescale_chk #(.MAG_W(MAG_W), .SPM_W($clog2(SPM))) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .osc_ce   (osc_ce),
   .halt     (halt),
   .sec_tick (sec_tick),
   .wave_raw (wave_raw),
   .adj      (adj),
   .act_mag  (act_mag),
   .sec_idx  (sec_idx),
   .min_idx  (min_idx)
);

// File: tb/tb_cal_prescale.sv
`timescale 1ns/1ps
module tb_cal_prescale;
   localparam int SEC_W  = 7;
   localparam int LO_W   = 4;
   localparam int TEST_W = 6;
   localparam int MAG_W  = 5;
   localparam int SPM    = 2;
   localparam int NOM    = 2 ** SEC_W;                 // 128
   localparam int FASTP  = NOM - (2 ** LO_W);          // 112
   localparam int SLOWP  = NOM + (2 ** (LO_W - 1));    // 136
   localparam int SPC    = SPM * (2 ** (MAG_W + 1));   // seconds per cycle
   localparam int WPER   = 2 ** TEST_W;
   localparam int NVEC   = 6;
   // {trim_up, trim_mag}
   localparam logic [5:0] VEC [NVEC] = '{
      {1'b1, 5'd1}, {1'b0, 5'd3}, {1'b1, 5'd31},
      {1'b0, 5'd31}, {1'b0, 5'd0}, {1'b1, 5'd6}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic osc_ce = 1'b0;
   logic [MAG_W-1:0] trim_mag = '0;
   logic trim_up = 1'b0;
   logic halt = 1'b0;
   logic ftest_en = 1'b0;
   logic sec_read = 1'b0;
   logic sec_tick, ftest_out, ftest_drive;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cal_prescale #(.SEC_W(SEC_W), .LO_W(LO_W), .TEST_W(TEST_W),
                  .MAG_W(MAG_W), .SPM(SPM)) dut (
      .clk(clk), .rst_n(rst_n), .osc_ce(osc_ce), .trim_mag(trim_mag),
      .trim_up(trim_up), .halt(halt), .ftest_en(ftest_en), .sec_read(sec_read),
      .sec_tick(sec_tick), .ftest_out(ftest_out), .ftest_drive(ftest_drive));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Counts enables consumed at posedges up to and including the tick.
   task automatic next_tick(output int n);
      n = 0;
      forever begin
         @(negedge clk);
         if (osc_ce && !halt) n++;
         if (sec_tick) return;
      end
   endtask

   // Test-wave period monitor (R8): only reads DUT outputs and bench inputs.
   int  w_cnt = 0, w_seen = 0, w_bad = 0, w_last = 0;
   bit  w_valid = 1'b0, w_prev = 1'b0;
   always @(negedge clk) begin
      if (!rst_n || !ftest_drive) begin
         w_valid = 1'b0; w_prev = 1'b0; w_cnt = 0;
      end else begin
         if (osc_ce && !halt) w_cnt++;
         if (ftest_out && !w_prev) begin
            if (w_valid) begin
               w_seen++;
               if (w_cnt != WPER) begin w_bad++; w_last = w_cnt; end
            end
            w_valid = 1'b1;
            w_cnt = 0;
         end
         w_prev = ftest_out;
      end
   end

   initial begin
      #(190000 * 10);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n, p, mn, exp_p, tot, exp_tot;
      logic [5:0] cur;
      // R9 / R5: reset with a nonzero trim on the inputs
      trim_up = 1'b1; trim_mag = 5'd31;
      osc_ce = 1'b1; ftest_en = 1'b1; sec_read = 1'b1;
      repeat (4) @(negedge clk);
      check(sec_tick == 1'b0, "R9 tick in reset", sec_tick, 0);
      check(ftest_out == 1'b0, "R9 wave in reset", ftest_out, 0);
      #2 rst_n = 1'b1;

      for (int c = 0; c <= NVEC; c++) begin
         cur = (c == 0) ? 6'd0 : VEC[c-1];
         tot = 0; exp_tot = 0;
         for (int s = 0; s < SPC; s++) begin
            next_tick(n);
            p  = s % SPM;
            mn = s / SPM;
            exp_p = NOM;
            if (p == 0 && mn < 2 * int'(cur[4:0])) exp_p = cur[5] ? FASTP : SLOWP;
            tot += n; exp_tot += exp_p;
            // R2 R3 R4 R5: each second of the cycle
            check(n == exp_p, $sformatf("R2/R3/R4/R5 cyc%0d sec%0d", c, s), n, exp_p);
            if (s == 5 && c < NVEC) begin
               #2 {trim_up, trim_mag} = VEC[c];
            end
         end
         check(tot == exp_tot, $sformatf("R1 cycle%0d total", c), tot, exp_tot);
      end
      // R8: wave period unchanged across all trimmed cycles
      check(w_seen > 100 && w_bad == 0, "R8 wave period", w_bad == 0 ? WPER : w_last, WPER);

      // Directed phase: fresh reset, zero trim
      @(negedge clk); #2;
      rst_n = 1'b0; trim_up = 1'b0; trim_mag = '0; ftest_en = 1'b0; sec_read = 1'b0;
      repeat (2) @(negedge clk);
      check(sec_tick == 1'b0 && ftest_out == 1'b0, "R9 second reset", sec_tick, 0);
      #2 rst_n = 1'b1;
      next_tick(n);
      check(n == NOM, "R1 first second after reset", n, NOM);

      // R7 gating
      #2 ftest_en = 1'b1; sec_read = 1'b0;
      @(negedge clk);
      check(ftest_drive == 1'b0 && ftest_out == 1'b0, "R7 no read", ftest_drive, 0);
      #2 sec_read = 1'b1; halt = 1'b1;
      @(negedge clk);
      check(ftest_drive == 1'b0, "R7 halted", ftest_drive, 0);
      #2 halt = 1'b0;
      @(negedge clk);
      check(ftest_drive == 1'b1, "R7 enabled", ftest_drive, 1);
      #2 ftest_en = 1'b0;
      @(negedge clk);
      check(ftest_drive == 1'b0 && ftest_out == 1'b0, "R7 test off", ftest_drive, 0);
      #2 ftest_en = 1'b1;
      // R7: driven wave period over several periods
      w_seen = 0; w_bad = 0;
      next_tick(n);  // resynchronise on a tick
      repeat (3 * WPER) @(negedge clk);
      check(w_seen >= 2 && w_bad == 0, "R7 wave period", w_bad == 0 ? WPER : w_last, WPER);
      next_tick(n);

      // R10: gapped enables
      fork
         next_tick(n);
         begin
            for (int k = 0; k < 3 * NOM; k++) begin
               @(negedge clk); #2 osc_ce = ~osc_ce;
               if (sec_tick) break;
            end
         end
      join
      #2 osc_ce = 1'b1;
      check(n == NOM, "R10 gapped enables", n, NOM);
      next_tick(n);

      // R6: halt in mid-second
      fork
         next_tick(n);
         begin
            int bad;
            bad = 0;
            repeat (40) @(negedge clk);
            #2 halt = 1'b1;
            repeat (30) begin
               @(negedge clk);
               if (sec_tick) bad++;
            end
            check(bad == 0, "R6 tick while halted", bad, 0);
            #2 halt = 1'b0;
         end
      join
      check(n == NOM, "R6 resume keeps count", n, NOM);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule